// File: doc/BRIEF.md
# Spindle Commutation Preload with Shoot-Through Interlock

This block drives the six gate enables of a three-phase spindle bridge. Each of the phases A, B and C has a high-side switch and a low-side switch. Firmware writes an 8-bit preload word through a simple write port. The written pattern is held until the next rising edge of the spindle clock, and only then does it reach the bridge. The spindle clock is sampled in the system clock domain, so every update occurs a fixed number of system cycles after a spindle edge.

Each phase passes through an interlock before it reaches the bridge. The interlock never lets the two switches of a phase conduct together. Whenever a phase changes from one side to the other, it also holds both switches off for a parameterised dead time.

When all six enable bits are written as ones, the word does not drive the gates directly. Instead it arms a six-step commutation counter. The counter starts at the BC step on the next spindle edge and then advances one step per spindle edge. Any other pattern stops the counter, returns it to BC and hands the gates back to the register bits.

Top module: `spindle_preload`

## Requirements
- R1: After reset, all six gate enables are 0, `comm_run` is 0 and `comm_step` is 0 (the BC step).
- R2: A write with `wr_addr` equal to parameter ADDR (default 4'b0011) loads the preload word. Writes to any other address are ignored. A loaded word changes no output until a rising `spin_clk` edge has been sampled.
- R3: In the preload word, bits 2:0 request the low side of phases A, B and C, and bits 5:3 request the high side of A, B and C. Bit 0 of each gate vector is phase A and bit 2 is phase C. Bits 7:6 have no effect.
- R4: For a phase whose high and low bits are both 1, only the high-side gate is enabled.
- R5: For every phase, in every cycle, `gate_hi` and `gate_lo` are never 1 together.
- R6: When a phase moves from one side to the opposite side, both of its gates are 0 for exactly DEAD+1 consecutive clock cycles (default DEAD = 3).
- R7: A spindle edge that samples bits 5:0 all at 1 while the counter is stopped sets `comm_run` to 1 at step 0 (BC). In that state the high side of B and the low side of C are on.
- R8: While the counter is running, each further spindle edge advances `comm_step` through 0..5 and then wraps to 0. The steps drive high/low as B/C, B/A, C/A, C/B, A/B and A/C, and the register bits are ignored.
- R9: A spindle edge that samples any other pattern in bits 5:0 clears `comm_run` and `comm_step`. The gates then follow the register bits again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| spin_clk | input | 1 | Spindle clock, sampled on clk |
| gate_hi | output | 3 | High-side enables, bit 0 = phase A |
| gate_lo | output | 3 | Low-side enables, bit 0 = phase A |
| comm_run | output | 1 | Commutation counter running |
| comm_step | output | 3 | Commutation step index, 0 = BC |

## Verification
The hardest situation to reach from the ports is a direct swap of one phase from low side to high side, or back, because that is the only case in which the dead time shows as a measurable gap. The stimulus first settles phase A on one side. It then writes the opposite side and raises the spindle clock, and counts the sampled cycles in which both gates of that phase are off. A sweep of all 63 non-arming patterns, applied one after another, swaps every phase many times. During that sweep a monitor checks for overlap in every cycle.

// File: rtl/spindle_preload.sv
module spindle_preload #(
  parameter logic [3:0] ADDR = 4'b0011,
  parameter int DEAD = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       spin_clk,
  output logic [2:0] gate_hi,
  output logic [2:0] gate_lo,
  output logic       comm_run,
  output logic [2:0] comm_step
);

  localparam int CW = $clog2(DEAD + 1);

  logic [7:0] pre;
  logic [5:0] cmd;
  logic       spin_q;
  logic       spin_rise;
  logic       armed;
  logic       run;
  logic [2:0] step;
  logic [2:0] seq_hi, seq_lo;
  logic [2:0] want_hi, want_lo;
  logic [2:0] hi_q, lo_q;

  assign spin_rise = spin_clk & ~spin_q;
  assign armed     = &pre[5:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre    <= '0;
      spin_q <= 1'b0;
    end else begin
      spin_q <= spin_clk;
      if (wr_en && wr_addr == ADDR) pre <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd  <= '0;
      run  <= 1'b0;
      step <= '0;
    end else if (spin_rise) begin
      cmd <= pre[5:0];
      if (armed) begin
        run  <= 1'b1;
        step <= !run ? 3'd0 : (step == 3'd5 ? 3'd0 : step + 3'd1);
      end else begin
        run  <= 1'b0;
        step <= 3'd0;
      end
    end
  end

  always_comb begin
    case (step)
      3'd0:    begin seq_hi = 3'b010; seq_lo = 3'b100; end
      3'd1:    begin seq_hi = 3'b010; seq_lo = 3'b001; end
      3'd2:    begin seq_hi = 3'b100; seq_lo = 3'b001; end
      3'd3:    begin seq_hi = 3'b100; seq_lo = 3'b010; end
      3'd4:    begin seq_hi = 3'b001; seq_lo = 3'b010; end
      3'd5:    begin seq_hi = 3'b001; seq_lo = 3'b100; end
      default: begin seq_hi = 3'b000; seq_lo = 3'b000; end
    endcase
  end

  assign want_hi = run ? seq_hi : cmd[5:3];
  assign want_lo = run ? seq_lo : (cmd[2:0] & ~cmd[5:3]);

  for (genvar i = 0; i < 3; i++) begin : g_phase
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hi_q[i] <= 1'b0;
        lo_q[i] <= 1'b0;
        cnt     <= '0;
      end else if ((hi_q[i] && !want_hi[i]) || (lo_q[i] && !want_lo[i])) begin
        hi_q[i] <= 1'b0;
        lo_q[i] <= 1'b0;
        cnt     <= CW'(DEAD);
      end else if (!hi_q[i] && !lo_q[i]) begin
        if (cnt != '0)   cnt     <= cnt - 1'b1;
        else if (want_hi[i]) hi_q[i] <= 1'b1;
        else if (want_lo[i]) lo_q[i] <= 1'b1;
      end
    end

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_q[i] && lo_q[i]));
    assert_lo_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_q[i]) |-> !$past(hi_q[i]));
    assert_hi_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_q[i]) |-> !$past(lo_q[i]));
  end

  assign gate_hi   = hi_q;
  assign gate_lo   = lo_q;
  assign comm_run  = run;
  assign comm_step = step;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !spin_rise |=> $stable(cmd) && $stable(step) && $stable(run));
  assert_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> step == 3'd0 && $past(pre[5:0]) == 6'h3F);
  assert_step_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step <= 3'd5);
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> step == 3'd0);

endmodule

// File: tb/tb_spindle_preload.sv
module tb_spindle_preload;
  localparam int CLK_PERIOD = 10;
  localparam int DEAD = 3;
  localparam int SETTLE = 2 * DEAD + 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       spin_clk = 1'b0;
  logic [2:0] gate_hi, gate_lo;
  logic       comm_run;
  logic [2:0] comm_step;

  int checks = 0;
  int fails = 0;
  int overlaps = 0;
  bit done = 1'b0;

  spindle_preload #(.ADDR(4'b0011), .DEAD(DEAD)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .spin_clk(spin_clk), .gate_hi(gate_hi),
    .gate_lo(gate_lo), .comm_run(comm_run), .comm_step(comm_step));

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk)
    if (rst_n && (gate_hi & gate_lo) != 3'b000) overlaps++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic spin();
    @(negedge clk); spin_clk = 1'b1;
    @(negedge clk); spin_clk = 1'b0;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic chk_gates(input logic [2:0] eh, input logic [2:0] el, input string req);
    chk(gate_hi == eh && gate_lo == el, req, {gate_hi, gate_lo}, {eh, el});
  endtask

  task automatic chk_step(input int k, input string req);
    logic [2:0] eh, el;
    eh = 3'b001 << ((k / 2 + 1) % 3);
    el = 3'b001 << (((k + 1) / 2 + 2) % 3);
    chk_gates(eh, el, req);
    chk(comm_run && comm_step == k[2:0], req, {comm_run, comm_step}, {1'b1, k[2:0]});
  endtask

  task automatic gap(output int n);
    n = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (!gate_hi[0] && !gate_lo[0]) n++;
      if (c > 1 && (gate_hi[0] || gate_lo[0])) break;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] ph, pl, eh, el;
    int n;
    repeat (3) @(negedge clk);
    chk_gates(3'b000, 3'b000, "R1");
    chk(!comm_run && comm_step == 0, "R1", {comm_run, comm_step}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: write held until a spindle edge
    wr(4'b0011, 8'h07);
    repeat (4) @(negedge clk);
    chk_gates(3'b000, 3'b000, "R2 hold");
    spin(); settle();
    chk_gates(3'b000, 3'b111, "R3 low bits");

    // R2: other address ignored
    wr(4'b0010, 8'h38);
    spin(); settle();
    chk_gates(3'b000, 3'b111, "R2 addr");

    // R3 R4 R9: sweep all non-arming patterns, spare bits varied
    ph = 3'b000; pl = 3'b111;
    for (int p = 0; p < 63; p++) begin
      logic [5:0] q;
      q = p[5:0];
      wr(4'b0011, {q[1:0], q});
      repeat (2) @(negedge clk);
      chk_gates(ph, pl, "R2 sweep hold");
      spin(); settle();
      eh = q[5:3]; el = q[2:0] & ~q[5:3];
      chk_gates(eh, el, "R4 sweep");
      chk(!comm_run && comm_step == 0, "R9 sweep", {comm_run, comm_step}, 0);
      ph = eh; pl = el;
    end

    // R6: dead time on phase A swaps
    wr(4'b0011, 8'h01); spin(); settle();
    chk_gates(3'b000, 3'b001, "R3 lowA");
    wr(4'b0011, 8'h08); spin(); gap(n); settle();
    chk(n == DEAD + 1, "R6 lo->hi", n, DEAD + 1);
    chk_gates(3'b001, 3'b000, "R3 highA");
    wr(4'b0011, 8'h01); spin(); gap(n); settle();
    chk(n == DEAD + 1, "R6 hi->lo", n, DEAD + 1);

    // R7 R8: arm and run through the sequence
    wr(4'b0011, 8'h3F);
    repeat (3) @(negedge clk);
    chk(!comm_run, "R7 not before edge", comm_run, 0);
    spin(); settle();
    chk_step(0, "R7 start BC");
    for (int k = 1; k <= 7; k++) begin
      spin(); settle();
      chk_step(k % 6, "R8 step");
    end

    // R9: non-all-ones stops counter only at spindle edge
    wr(4'b0011, 8'hC7);
    repeat (3) @(negedge clk);
    chk_step(1, "R9 hold until edge");
    spin(); settle();
    chk_gates(3'b000, 3'b111, "R9 stop");
    chk(!comm_run && comm_step == 0, "R9 reset", {comm_run, comm_step}, 0);

    // R7: restart at BC
    wr(4'b0011, 8'hFF); spin(); settle();
    chk_step(0, "R7 restart");
    spin(); settle();
    chk_step(1, "R8 after restart");

    chk(overlaps == 0, "R5 overlap", overlaps, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule